// File: doc/BRIEF.md
# Status-Modified Interrupt Vector Register

This block holds the interrupt vector of a two-channel serial controller and produces the value returned when software reads that vector back. Software programs an 8-bit vector through a write strobe on channel B, and sets or clears a vector-modify control bit through a second write strobe on channel B. A read strobe on channel B returns the vector one clock later, qualified by a valid flag. A read strobe on channel A returns no data.

When the modify bit is clear, the readback is the programmed vector unchanged. When the modify bit is set, bits 3..1 of the readback are replaced by a three-bit code. The code names the highest-priority source among the eight pending flags, which are four per channel. If nothing is pending, the code reports a channel B special-receive condition. The pending flags come from the channel logic. The daisy chain and the acknowledge cycle are handled elsewhere.

Top module: `irq_vector_reg`

## Requirements
- R1: After reset the stored vector is 8'h00 and the modify bit is clear, so a channel B read returns 8'h00.
- R2: With the modify bit clear, a channel B read returns the last vector written through channel B unchanged, whatever the pending flags are.
- R3: Vector and control write strobes issued with chan_sel=0 (channel A) change neither the stored vector nor the modify bit.
- R4: A read strobe with chan_sel=0 gives rd_valid=0 and rdata=8'h00 on the next cycle.
- R5: With the modify bit set (wdata bit 2 of a channel B control write), readback bits 7..4 and bit 0 equal the stored vector, and bits 3..1 carry the source code.
- R6: The source code is {channel, kind}, where channel is 1 for A and 0 for B, and kind is 00 for transmit empty, 01 for external status, 10 for receive available and 11 for special receive. Pending flag bit positions are [0] transmit empty, [1] external status, [2] receive available and [3] special receive.
- R7: Priority is fixed. Every channel A source ranks above every channel B source. Within a channel the order is special receive, then receive available, then transmit empty, then external status.
- R8: With the modify bit set and no flag pending, the code is 3'b011.
- R9: rd_valid is high exactly in the cycle after a channel B read strobe. rdata reflects the state present at the strobe edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_sel | input | 1 | Channel addressed by the strobes: 1 = B, 0 = A |
| vec_wr | input | 1 | Vector register write strobe |
| ctl_wr | input | 1 | Control register write strobe (bit 2 = modify) |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Vector register read strobe |
| pend_a | input | 4 | Channel A pending flags |
| pend_b | input | 4 | Channel B pending flags |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data qualifier |

## Verification
A corrupted stored vector shows up on the first channel B read after the corruption, in every readback bit when the modify bit is clear. A lost or stuck modify bit shows up as an echo where a code was expected, or as a code where an echo was expected, and is visible on the next read. An encoder fault appears only when a read coincides with the faulty combination of pending flags. The bench therefore drives single sources, pairs that straddle the priority order, and the empty case.

// File: rtl/irq_vector_reg.sv
module irq_vector_reg #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_sel,
  input  logic             vec_wr,
  input  logic             ctl_wr,
  input  logic [VEC_W-1:0] wdata,
  input  logic             rd_en,
  input  logic [3:0]       pend_a,
  input  logic [3:0]       pend_b,
  output logic [VEC_W-1:0] rdata,
  output logic             rd_valid
);
  localparam int MOD_BIT = 2;

  logic [VEC_W-1:0] vec_q;
  logic             mod_q;
  logic [2:0]       code;
  logic [VEC_W-1:0] view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      mod_q <= 1'b0;
    end else begin
      if (vec_wr && chan_sel) vec_q <= wdata;
      if (ctl_wr && chan_sel) mod_q <= wdata[MOD_BIT];
    end
  end

  // fixed priority: A over B; special, receive, transmit, external
  always_comb begin
    if      (pend_a[3]) code = 3'b111;
    else if (pend_a[2]) code = 3'b110;
    else if (pend_a[0]) code = 3'b100;
    else if (pend_a[1]) code = 3'b101;
    else if (pend_b[3]) code = 3'b011;
    else if (pend_b[2]) code = 3'b010;
    else if (pend_b[0]) code = 3'b000;
    else if (pend_b[1]) code = 3'b001;
    else                code = 3'b011;
  end

  always_comb begin
    view = vec_q;
    if (mod_q) view[3:1] = code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en && chan_sel;
      rdata    <= (rd_en && chan_sel) ? view : '0;
    end
  end

  a_r3_chan_a_vec_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && !chan_sel) |=> $stable(vec_q));
  a_r3_chan_a_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !chan_sel) |=> $stable(mod_q));
  a_r4_chan_a_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !chan_sel) |=> (!rd_valid && rdata == '0));
  a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && chan_sel) |=> rd_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  a_r2_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && chan_sel && !mod_q) |=> rdata == $past(vec_q));
  a_r5_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && chan_sel && mod_q) |=>
      (rdata[VEC_W-1:4] == $past(vec_q[VEC_W-1:4]) && rdata[0] == $past(vec_q[0])));
  a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && chan_sel && mod_q && pend_a == 4'h0 && pend_b == 4'h0) |=> rdata[3:1] == 3'b011);
  a_r7_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && chan_sel && mod_q && pend_a != 4'h0) |=> rdata[3]);
endmodule

// File: tb/tb_irq_vector_reg.sv
`timescale 1ns/1ps
module tb_irq_vector_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_sel = 1'b0, vec_wr = 1'b0, ctl_wr = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [3:0] pend_a = '0, pend_b = '0;
  logic [7:0] rdata;
  logic       rd_valid;
  int checks = 0, fails = 0;
  logic [7:0] m_vec = '0;
  logic       m_mod = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_reg dut (.clk, .rst_n, .chan_sel, .vec_wr, .ctl_wr, .wdata,
                      .rd_en, .pend_a, .pend_b, .rdata, .rd_valid);

  function automatic logic [7:0] model(logic [7:0] v, logic m, logic [3:0] pa, logic [3:0] pb);
    logic [7:0] p;
    int order [8];
    logic [2:0] c;
    p = {pa, pb};
    order = '{7, 6, 4, 5, 3, 2, 0, 1};
    c = 3'b011;
    for (int i = 7; i >= 0; i--) if (p[order[i]]) c = 3'(order[i]);
    return m ? {v[7:4], c, v[0]} : v;
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic ch, logic is_ctl, logic [7:0] d);
    @(negedge clk);
    chan_sel = ch; vec_wr = !is_ctl; ctl_wr = is_ctl; wdata = d;
    @(negedge clk);
    vec_wr = 0; ctl_wr = 0;
    if (ch && !is_ctl) m_vec = d;
    if (ch && is_ctl) m_mod = d[2];
  endtask

  task automatic rd_check(string req, logic ch, logic [3:0] pa, logic [3:0] pb);
    @(negedge clk);
    chan_sel = ch; rd_en = 1; pend_a = pa; pend_b = pb;
    @(posedge clk); #1;
    rd_en = 0;
    if (ch) check(req, {rd_valid, rdata}, {1'b1, model(m_vec, m_mod, pa, pb)});
    else    check(req, {rd_valid, rdata}, 9'h000);
  endtask

  task automatic t_reset();
    rd_check("R1", 1, 4'h0, 4'h0);
    rd_check("R1", 1, 4'hF, 4'hF);
  endtask

  task automatic t_echo();
    wr(1, 0, 8'hA5); rd_check("R2", 1, 4'h0, 4'h0);
    wr(1, 0, 8'h3C); rd_check("R2", 1, 4'h9, 4'h6);
  endtask

  task automatic t_chan_a();
    wr(0, 0, 8'hFF); rd_check("R3", 1, 4'h0, 4'h0);
    wr(0, 1, 8'h04); rd_check("R3", 1, 4'h8, 4'h0);
    rd_check("R4", 0, 4'hF, 4'h0);
  endtask

  task automatic t_idle_valid();
    @(negedge clk); @(posedge clk); #1;
    check("R9", {8'h00, rd_valid}, 9'h000);
  endtask

  task automatic t_modify();
    wr(1, 0, 8'hA5); wr(1, 1, 8'h04);
    rd_check("R8", 1, 4'h0, 4'h0);
    check("R8", {1'b1, rdata}, {1'b1, 8'hA7});
    wr(1, 0, 8'h5A);
    rd_check("R5", 1, 4'h0, 4'h4);
  endtask

  task automatic t_codes();
    for (int i = 0; i < 4; i++) rd_check("R6", 1, 4'(1 << i), 4'h0);
    for (int i = 0; i < 4; i++) rd_check("R6", 1, 4'h0, 4'(1 << i));
  endtask

  task automatic t_priority();
    rd_check("R7", 1, 4'hF, 4'hF);
    rd_check("R7", 1, 4'h3, 4'h0);
    rd_check("R7", 1, 4'h0, 4'h3);
    rd_check("R7", 1, 4'h2, 4'hF);
    rd_check("R7", 1, 4'h0, 4'h6);
    rd_check("R7", 1, 4'h6, 4'h0);
  endtask

  task automatic t_unmodify();
    wr(1, 1, 8'hFB);
    rd_check("R2", 1, 4'hF, 4'hF);
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_echo();
    t_chan_a();
    t_idle_valid();
    t_modify();
    t_codes();
    t_priority();
    t_unmodify();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule